// File: doc/BRIEF.md
# Internal Function Pulse Decoder

This block carries out the "drive internal function" instruction of a small communications processor. When the execute strobe is high, each 1 in the 10-bit operand triggers its own fixed action. An action may set or clear one of four status flip-flops: control bit A, control bit B, the parity bit and the buzzer. It may also raise a one-cycle request strobe toward the hardware-load sequencer or toward the device selector. Several operand bits may be 1 in the same instruction, and all of their actions take effect together in the single clock edge that executes the instruction.

The flag-restore path of the processor uses a separate load port, with its own strobe, to write control bit A, control bit B and the parity bit directly. The buzzer is not written by this port. A synchronous reset clears every flip-flop and holds both strobes low.

The block has no state machine. The only sequential elements are the four flag cells and the two strobe registers, and each of them is updated on every edge from that cycle's inputs.

Top module: `ifd_top`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears all four flag outputs to 0, and both strobes are 0 in the following cycle, whatever the other inputs are.
- R2: When `exec_i` is high and `operand_i[1]` is 1, control bit A, control bit B and the parity bit are cleared at that edge, unless a set for a given flag or a load applies to it in the same cycle.
- R3: When `exec_i` is high, `operand_i[2]` clears the buzzer and `operand_i[3]` sets it. If both bits are 1, the buzzer ends up set.
- R4: When `exec_i` is high and `operand_i[4]` is 1, `hwload_req_o` is high for exactly the one cycle after that edge.
- R5: When `exec_i` is high and `operand_i[7]` is 1, `sel_pulse_o` is high for exactly the one cycle after that edge.
- R6: When `exec_i` is high, `operand_i[8]` sets control bit A, `operand_i[9]` sets control bit B and `operand_i[0]` sets the parity bit. A set takes priority over the clear requested by `operand_i[1]`.
- R7: `operand_i[5]` and `operand_i[6]` have no effect on any output.
- R8: Any combination of operand bits applies all of its actions in the same edge.
- R9: When `ld_en_i` is high at an edge, `cb_a_o`, `cb_b_o` and `par_o` take the values of `ld_cb_a_i`, `ld_cb_b_i` and `ld_par_i`, overriding any decoded action on those three flags. The buzzer and the strobes still follow the operand.
- R10: When neither `exec_i` nor `ld_en_i` is high, all flags keep their values and both strobes are 0 in the next cycle.
- R11: Every result of an instruction is visible in the cycle directly after the edge that samples `exec_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_i | input | 1 | Execute the instruction this cycle |
| operand_i | input | 10 | Function-select operand; bit k is position k, and index 0 is the position labelled 0 |
| ld_en_i | input | 1 | Flag-restore load strobe |
| ld_cb_a_i | input | 1 | Load value for control bit A |
| ld_cb_b_i | input | 1 | Load value for control bit B |
| ld_par_i | input | 1 | Load value for the parity bit |
| cb_a_o | output | 1 | Control bit A |
| cb_b_o | output | 1 | Control bit B |
| par_o | output | 1 | Parity bit |
| buzz_o | output | 1 | Buzzer flip-flop |
| hwload_req_o | output | 1 | One-cycle hardware-load request |
| sel_pulse_o | output | 1 | One-cycle selector strobe |

## Verification
Every output of this block sits exactly one register away from its inputs. All four flags and both strobes therefore change on the edge that samples `exec_i` or `ld_en_i`, and the bench checks them at the falling edge directly after. The bench drives its inputs at a falling edge and advances by one rising edge per step. Before each edge it updates a reference copy of the flags computed from the requirements, so every step compares all six outputs against values due in that same cycle. It runs exhaustive sweeps of all 1024 operands with execute high, with execute low, and interleaved with loads.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
    localparam int OPW      = 10;
    localparam int N_STROBE = 2;
    localparam int N_LDFLAG = 3;

    // operand position of each function
    localparam int POS_GRP_CLR = 1;
    localparam int POS_BZ_CLR  = 2;
    localparam int POS_BZ_SET  = 3;
    localparam int POS_HWLOAD  = 4;
    localparam int POS_SELECT  = 7;
    localparam int POS_SET_A   = 8;
    localparam int POS_SET_B   = 9;
    localparam int POS_SET_PAR = 0;

    // strobe bank slots
    localparam int STB_HWLOAD = 0;
    localparam int STB_SELECT = 1;

    typedef struct packed {
        logic [N_LDFLAG-1:0] set_ld;   // {par, b, a}
        logic                clr_grp;
        logic                set_bz;
        logic                clr_bz;
        logic [N_STROBE-1:0] fire;
    } ifd_act_t;
endpackage

// File: rtl/ifd_decode.sv
module ifd_decode
    import ifd_pkg::*;
(
    input  logic           exec_i,
    input  logic [OPW-1:0] operand_i,
    output ifd_act_t       act_o
);
    always_comb begin
        act_o                     = '0;
        act_o.set_ld[0]           = exec_i & operand_i[POS_SET_A];
        act_o.set_ld[1]           = exec_i & operand_i[POS_SET_B];
        act_o.set_ld[2]           = exec_i & operand_i[POS_SET_PAR];
        act_o.clr_grp             = exec_i & operand_i[POS_GRP_CLR];
        act_o.set_bz              = exec_i & operand_i[POS_BZ_SET];
        act_o.clr_bz              = exec_i & operand_i[POS_BZ_CLR];
        act_o.fire[STB_HWLOAD]    = exec_i & operand_i[POS_HWLOAD];
        act_o.fire[STB_SELECT]    = exec_i & operand_i[POS_SELECT];
    end
endmodule

// File: rtl/ifd_flag_cell.sv
module ifd_flag_cell #(
    parameter bit HAS_LOAD = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic ld_en_i,
    input  logic ld_val_i,
    output logic q_o
);
    logic ld_go;

    generate
        if (HAS_LOAD) begin : g_ld
            assign ld_go = ld_en_i;
        end else begin : g_no_ld
            assign ld_go = 1'b0 & ld_en_i & ld_val_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (ld_go) q_o <= ld_val_i;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/ifd_strobe_bank.sv
module ifd_strobe_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] fire_i,
    output logic [N-1:0] pulse_o
);
    generate
        for (genvar k = 0; k < N; k++) begin : g_stb
            always_ff @(posedge clk) begin
                if (rst) pulse_o[k] <= 1'b0;
                else     pulse_o[k] <= fire_i[k];
            end
        end
    endgenerate
endmodule

// File: rtl/ifd_top.sv
module ifd_top
    import ifd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           exec_i,
    input  logic [OPW-1:0] operand_i,
    input  logic           ld_en_i,
    input  logic           ld_cb_a_i,
    input  logic           ld_cb_b_i,
    input  logic           ld_par_i,
    output logic           cb_a_o,
    output logic           cb_b_o,
    output logic           par_o,
    output logic           buzz_o,
    output logic           hwload_req_o,
    output logic           sel_pulse_o
);
    ifd_act_t              act;
    logic [N_LDFLAG-1:0]   ld_vals;
    logic [N_LDFLAG-1:0]   flag_q;
    logic [N_STROBE-1:0]   pulses;

    assign ld_vals = {ld_par_i, ld_cb_b_i, ld_cb_a_i};

    ifd_decode u_dec (
        .exec_i    (exec_i),
        .operand_i (operand_i),
        .act_o     (act)
    );

    generate
        for (genvar f = 0; f < N_LDFLAG; f++) begin : g_flag
            ifd_flag_cell #(.HAS_LOAD(1'b1)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .set_i    (act.set_ld[f]),
                .clr_i    (act.clr_grp),
                .ld_en_i  (ld_en_i),
                .ld_val_i (ld_vals[f]),
                .q_o      (flag_q[f])
            );
        end
    endgenerate

    ifd_flag_cell #(.HAS_LOAD(1'b0)) u_buzz (
        .clk      (clk),
        .rst      (rst),
        .set_i    (act.set_bz),
        .clr_i    (act.clr_bz),
        .ld_en_i  (1'b0),
        .ld_val_i (1'b0),
        .q_o      (buzz_o)
    );

    ifd_strobe_bank #(.N(N_STROBE)) u_stb (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (act.fire),
        .pulse_o (pulses)
    );

    assign cb_a_o       = flag_q[0];
    assign cb_b_o       = flag_q[1];
    assign par_o        = flag_q[2];
    assign hwload_req_o = pulses[STB_HWLOAD];
    assign sel_pulse_o  = pulses[STB_SELECT];
endmodule

// File: rtl/ifd_top_chk.sv
module ifd_top_chk (
    input logic       clk,
    input logic       rst,
    input logic       exec_i,
    input logic [9:0] operand_i,
    input logic       ld_en_i,
    input logic       ld_cb_a_i,
    input logic       ld_cb_b_i,
    input logic       ld_par_i,
    input logic       cb_a_o,
    input logic       cb_b_o,
    input logic       par_o,
    input logic       buzz_o,
    input logic       hwload_req_o,
    input logic       sel_pulse_o
);
    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> {cb_a_o, cb_b_o, par_o, buzz_o, hwload_req_o, sel_pulse_o} == 6'b0); // R1
    AST_GRP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (exec_i && operand_i[1] && !operand_i[8] && !ld_en_i) |=> !cb_a_o); // R2
    AST_BUZZ_SET: assert property (@(posedge clk) disable iff (rst)
        (exec_i && operand_i[3]) |=> buzz_o); // R3
    AST_BUZZ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (exec_i && operand_i[2] && !operand_i[3]) |=> !buzz_o); // R3
    AST_HWLOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> hwload_req_o == $past(exec_i && operand_i[4])); // R4
    AST_SEL_PULSE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sel_pulse_o == $past(exec_i && operand_i[7])); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (exec_i && operand_i[9] && !ld_en_i) |=> cb_b_o); // R6
    AST_LOAD_PRIO: assert property (@(posedge clk) disable iff (rst)
        ld_en_i |=> {cb_a_o, cb_b_o, par_o} == $past({ld_cb_a_i, ld_cb_b_i, ld_par_i})); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!exec_i && !ld_en_i) |=> $stable({cb_a_o, cb_b_o, par_o, buzz_o})); // R10
endmodule

bind ifd_top ifd_top_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .exec_i       (exec_i),
    .operand_i    (operand_i),
    .ld_en_i      (ld_en_i),
    .ld_cb_a_i    (ld_cb_a_i),
    .ld_cb_b_i    (ld_cb_b_i),
    .ld_par_i     (ld_par_i),
    .cb_a_o       (cb_a_o),
    .cb_b_o       (cb_b_o),
    .par_o        (par_o),
    .buzz_o       (buzz_o),
    .hwload_req_o (hwload_req_o),
    .sel_pulse_o  (sel_pulse_o)
);

// File: tb/ifd_top_tb_top.sv
module ifd_top_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       exec_i;
    logic [9:0] operand_i;
    logic       ld_en_i, ld_cb_a_i, ld_cb_b_i, ld_par_i;
    logic       cb_a_o, cb_b_o, par_o, buzz_o, hwload_req_o, sel_pulse_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic m_a, m_b, m_p, m_z;

    always #2 clk = ~clk;

    ifd_top dut_i (
        .clk(clk), .rst(rst), .exec_i(exec_i), .operand_i(operand_i),
        .ld_en_i(ld_en_i), .ld_cb_a_i(ld_cb_a_i), .ld_cb_b_i(ld_cb_b_i), .ld_par_i(ld_par_i),
        .cb_a_o(cb_a_o), .cb_b_o(cb_b_o), .par_o(par_o), .buzz_o(buzz_o),
        .hwload_req_o(hwload_req_o), .sel_pulse_o(sel_pulse_o)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {a,b,par,buzz,hwl,sel} actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive at a falling edge, one rising edge, compare at the next falling edge
    task automatic step(input logic ex, input logic [9:0] op, input logic le,
                        input logic [2:0] lv, input string tag);
        logic eh, es;
        exec_i = ex; operand_i = op; ld_en_i = le;
        {ld_par_i, ld_cb_b_i, ld_cb_a_i} = lv;
        eh = ex & op[4];
        es = ex & op[7];
        if (le) begin
            {m_p, m_b, m_a} = lv;
        end else if (ex) begin
            if (op[1]) begin m_a = 1'b0; m_b = 1'b0; m_p = 1'b0; end
            if (op[8]) m_a = 1'b1;
            if (op[9]) m_b = 1'b1;
            if (op[0]) m_p = 1'b1;
        end
        if (ex) begin
            if (op[2]) m_z = 1'b0;
            if (op[3]) m_z = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {cb_a_o, cb_b_o, par_o, buzz_o, hwload_req_o, sel_pulse_o},
                   {m_a, m_b, m_p, m_z, eh, es});
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; exec_i = 1'b1; operand_i = 10'h3FF;
        ld_en_i = 1'b1; ld_cb_a_i = 1'b1; ld_cb_b_i = 1'b1; ld_par_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {cb_a_o, cb_b_o, par_o, buzz_o, hwload_req_o, sel_pulse_o}, 6'b0);
        rst = 1'b0;
        m_a = 0; m_b = 0; m_p = 0; m_z = 0;

        // targeted cases
        step(0, 10'h000, 1, 3'b111, "R9");
        step(1, 10'h002, 0, 3'b000, "R2");
        step(1, 10'h008, 0, 3'b000, "R3");
        step(1, 10'h004, 0, 3'b000, "R3");
        step(1, 10'h00C, 0, 3'b000, "R3");
        step(1, 10'h010, 0, 3'b000, "R4");
        step(0, 10'h000, 0, 3'b000, "R4");
        step(1, 10'h080, 0, 3'b000, "R5");
        step(0, 10'h000, 0, 3'b000, "R5");
        step(1, 10'h303, 0, 3'b000, "R6");
        step(1, 10'h060, 0, 3'b000, "R7");
        step(1, 10'h002, 0, 3'b000, "R2");
        step(1, 10'h060, 0, 3'b000, "R7");
        step(1, 10'h39F, 1, 3'b010, "R9");
        step(1, 10'h29D, 0, 3'b000, "R11");

        // exhaustive sweeps
        for (int i = 0; i < 1024; i++) step(1, 10'(i), 0, 3'b000, "R8");
        for (int i = 0; i < 1024; i++) step(0, 10'(i ^ 10'h155), 0, 3'b000, "R10");
        for (int i = 0; i < 1024; i++)
            step(1, 10'(i), (i % 3) == 0, 3'(i * 5), "R9");

        // reset mid-run
        rst = 1'b1; exec_i = 1'b1; operand_i = 10'h3FF; ld_en_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", {cb_a_o, cb_b_o, par_o, buzz_o, hwload_req_o, sel_pulse_o}, 6'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule